// File: doc/BRIEF.md
# Token-Counting Coherence Controller

This block keeps coherence permission for the lines of one cache by counting tokens. Every line in the system owns a fixed number of tokens, set by the `TOKENS` parameter. The controller records how many of them its cache holds for each line. It grants a local read while it holds at least one token, and a local write only while it holds every token. Because tokens are conserved, at most one cache can write a line at any moment, and no cache can write while another still holds a token. This rules out a writer coexisting with readers, without any ordered bus or acknowledgement scheme.

Tokens move between caches inside messages that also carry a data-valid flag, so the count and the line's data travel together. Other caches ask for tokens with shared or exclusive requests, and this controller answers them on its outgoing port. When its own processor request lacks tokens, the request stalls and the controller sends a token request of its own. Message ordering in the interconnect, starvation avoidance and line replacement are handled elsewhere.

Top module: `tc_coherence_ctrl`

## Requirements
- R1: After reset every line holds zero tokens, no processor request is granted and `out_valid` is low.
- R2: An incoming transfer (`in_kind` = 0) with a nonzero token count adds that count to the addressed line, effective from the next cycle.
- R3: A line's count never exceeds `TOKENS`. A transfer that would push it past `TOKENS` is flagged by an assertion, and the count is clamped at `TOKENS`. Filling a line to exactly `TOKENS` in several transfers is legal.
- R4: A read request (`cpu_req_write` = 0) is granted in the same cycle, through `cpu_grant`, when the addressed line holds at least one token.
- R5: A write request (`cpu_req_write` = 1) is granted in the same cycle only when the addressed line holds all `TOKENS` tokens.
- R6: An exclusive request from elsewhere (`in_kind` = 2) for a line holding tokens produces, one cycle later, an outgoing transfer (`out_kind` = 0) carrying all of those tokens with `out_data_valid` = 1, and the line's count becomes zero. With zero tokens held, nothing is sent.
- R7: A shared request from elsewhere (`in_kind` = 1) for a line holding more than one token produces, one cycle later, an outgoing transfer of exactly one token with `out_data_valid` = 1, and the count drops by one. With one or zero tokens held, nothing is sent and the count is unchanged.
- R8: A processor request that is not granted sends, one cycle later, a token request for its address with zero tokens and `out_data_valid` = 0. The request is shared (`out_kind` = 1) for a read and exclusive (`out_kind` = 2) for a write. Only one such message is sent while the request stays raised and ungranted.
- R9: When an answer to another cache and the processor's token request fall in the same cycle, the answer takes the outgoing port, and the token request follows in the next cycle.
- R10: A transfer with `in_data_valid` = 0 is accepted only if the line already holds at least one token; otherwise it is ignored. Messages with `in_kind` = 3 are ignored.
- R11: Each line's count changes only through messages addressed to that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until granted |
| cpu_req_write | input | 1 | 1 = write permission wanted, 0 = read |
| cpu_req_addr | input | ADDR_W | Line index of the processor request |
| cpu_grant | output | 1 | Permission held for the request this cycle |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 2 | 0 transfer, 1 shared request, 2 exclusive request, 3 ignored |
| in_addr | input | ADDR_W | Line index of the incoming message |
| in_tokens | input | $clog2(TOKENS)+1 | Tokens carried by an incoming transfer |
| in_data_valid | input | 1 | Incoming message carries the line's data |
| out_valid | output | 1 | Outgoing message present (registered) |
| out_kind | output | 2 | Same encoding as `in_kind` |
| out_addr | output | ADDR_W | Line index of the outgoing message |
| out_tokens | output | $clog2(TOKENS)+1 | Tokens carried by the outgoing message |
| out_data_valid | output | 1 | Outgoing message carries the line's data |

## Verification
The bench builds the controller with `TOKENS` = 4 and `ADDR_W` = 2, so it has four lines. With that setting, every reachable count from zero to full can be set on every line. At each count the bench checks read and write grants, the shared-request response and the drained token total, which covers all decision points of the permission and response logic. With four lines it can also load a different count into each line and confirm that none leaks into another. It can also place a peer's exclusive request and a stalled write in the same cycle on different lines.

// File: rtl/tc_pkg.sv
package tc_pkg;

    // Message kind field shared by the incoming and outgoing ports.
    typedef enum logic [1:0] {
        MSG_XFER   = 2'd0,
        MSG_REQ_SH = 2'd1,
        MSG_REQ_EX = 2'd2,
        MSG_NONE   = 2'd3
    } msg_kind_e;

endpackage

// File: rtl/tc_line_table.sv
module tc_line_table #(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [CNT_W-1:0]  upd_count,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [CNT_W-1:0]  rd_a_count,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [CNT_W-1:0]  rd_b_count
);

    logic [CNT_W-1:0] cnt_arr [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [CNT_W-1:0] cnt_d;
        logic [CNT_W-1:0] cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (upd_en && (upd_addr == ADDR_W'(g))) begin
                cnt_d = upd_count;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign cnt_arr[g] = cnt_q;
    end

    assign rd_a_count = cnt_arr[rd_a_addr];
    assign rd_b_count = cnt_arr[rd_b_addr];

endmodule

// File: rtl/tc_snoop.sv
module tc_snoop
    import tc_pkg::*;
#(
    parameter int TOKENS = 4,
    parameter int CNT_W  = 3
) (
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [CNT_W-1:0] in_tokens,
    input  logic             in_data_valid,
    input  logic [CNT_W-1:0] cur_count,
    output logic             upd_en,
    output logic [CNT_W-1:0] upd_count,
    output logic             resp_valid,
    output logic [CNT_W-1:0] resp_tokens
);

    localparam logic [CNT_W:0]   MAX_SUM = (CNT_W+1)'(TOKENS);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(TOKENS);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W:0] sum;

    always_comb begin
        upd_en      = 1'b0;
        upd_count   = cur_count;
        resp_valid  = 1'b0;
        resp_tokens = '0;
        sum         = {1'b0, cur_count} + {1'b0, in_tokens};
        if (in_valid) begin
            case (msg_kind_e'(in_kind))
                MSG_XFER: begin
                    // Tokens without data may only join an existing copy.
                    if ((in_tokens != '0) && (in_data_valid || (cur_count != '0))) begin
                        upd_en    = 1'b1;
                        upd_count = (sum > MAX_SUM) ? MAX_CNT : sum[CNT_W-1:0];
                    end
                end
                MSG_REQ_EX: begin
                    if (cur_count != '0) begin
                        upd_en      = 1'b1;
                        upd_count   = '0;
                        resp_valid  = 1'b1;
                        resp_tokens = cur_count;
                    end
                end
                MSG_REQ_SH: begin
                    if (cur_count > ONE) begin
                        upd_en      = 1'b1;
                        upd_count   = cur_count - ONE;
                        resp_valid  = 1'b1;
                        resp_tokens = ONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/tc_permit.sv
module tc_permit #(
    parameter int TOKENS = 4,
    parameter int CNT_W  = 3
) (
    input  logic             req_write,
    input  logic [CNT_W-1:0] count,
    output logic             allowed
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(TOKENS);

    always_comb begin
        if (req_write) begin
            allowed = (count == MAX_CNT);
        end else begin
            allowed = (count != '0);
        end
    end

endmodule

// File: rtl/tc_coherence_ctrl.sv
module tc_coherence_ctrl
    import tc_pkg::*;
#(
    parameter int TOKENS = 4,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    input  logic                        cpu_req_write,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    output logic                        cpu_grant,
    input  logic                        in_valid,
    input  logic [1:0]                  in_kind,
    input  logic [ADDR_W-1:0]           in_addr,
    input  logic [$clog2(TOKENS):0]     in_tokens,
    input  logic                        in_data_valid,
    output logic                        out_valid,
    output logic [1:0]                  out_kind,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [$clog2(TOKENS):0]     out_tokens,
    output logic                        out_data_valid
);

    localparam int CNT_W     = $clog2(TOKENS) + 1;
    localparam int NUM_LINES = 1 << ADDR_W;

    typedef struct packed {
        logic              out_valid;
        logic [1:0]        out_kind;
        logic [ADDR_W-1:0] out_addr;
        logic [CNT_W-1:0]  out_tokens;
        logic              out_dv;
        logic              req_sent;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [CNT_W-1:0] cpu_count;
    logic [CNT_W-1:0] msg_count;
    logic             upd_en;
    logic [CNT_W-1:0] upd_count;
    logic             resp_valid;
    logic [CNT_W-1:0] resp_tokens;
    logic             permit_ok;

    tc_line_table #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .upd_addr   (in_addr),
        .upd_count  (upd_count),
        .rd_a_addr  (cpu_req_addr),
        .rd_a_count (cpu_count),
        .rd_b_addr  (in_addr),
        .rd_b_count (msg_count)
    );

    tc_snoop #(
        .TOKENS (TOKENS),
        .CNT_W  (CNT_W)
    ) u_snoop (
        .in_valid      (in_valid),
        .in_kind       (in_kind),
        .in_tokens     (in_tokens),
        .in_data_valid (in_data_valid),
        .cur_count     (msg_count),
        .upd_en        (upd_en),
        .upd_count     (upd_count),
        .resp_valid    (resp_valid),
        .resp_tokens   (resp_tokens)
    );

    tc_permit #(
        .TOKENS (TOKENS),
        .CNT_W  (CNT_W)
    ) u_permit (
        .req_write (cpu_req_write),
        .count     (cpu_count),
        .allowed   (permit_ok)
    );

    assign cpu_grant = cpu_req_valid && permit_ok;

    always_comb begin
        state_d            = state_q;
        state_d.out_valid  = 1'b0;
        state_d.out_kind   = MSG_XFER;
        state_d.out_addr   = '0;
        state_d.out_tokens = '0;
        state_d.out_dv     = 1'b0;

        if (resp_valid) begin
            // Answers to other caches always win the outgoing port.
            state_d.out_valid  = 1'b1;
            state_d.out_kind   = MSG_XFER;
            state_d.out_addr   = in_addr;
            state_d.out_tokens = resp_tokens;
            state_d.out_dv     = 1'b1;
        end else if (cpu_req_valid && !permit_ok && !state_q.req_sent) begin
            state_d.out_valid  = 1'b1;
            state_d.out_kind   = cpu_req_write ? MSG_REQ_EX : MSG_REQ_SH;
            state_d.out_addr   = cpu_req_addr;
            state_d.out_tokens = '0;
            state_d.out_dv     = 1'b0;
            state_d.req_sent   = 1'b1;
        end

        if (!cpu_req_valid || permit_ok) begin
            state_d.req_sent = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid      = state_q.out_valid;
    assign out_kind       = state_q.out_kind;
    assign out_addr       = state_q.out_addr;
    assign out_tokens     = state_q.out_tokens;
    assign out_data_valid = state_q.out_dv;

endmodule

// File: rtl/tc_coherence_ctrl_chk.sv
module tc_coherence_ctrl_chk #(
    parameter int TOKENS = 4,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic              cpu_grant,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [CNT_W-1:0]  in_tokens,
    input logic              in_data_valid,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic [CNT_W-1:0]  out_tokens,
    input logic              out_data_valid,
    input logic [CNT_W-1:0]  cpu_count,
    input logic [CNT_W-1:0]  msg_count
);

    localparam logic [CNT_W-1:0] MAXC  = CNT_W'(TOKENS);
    localparam logic [CNT_W:0]   MAXS  = (CNT_W+1)'(TOKENS);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    // R3: an accepted transfer must not carry the line past the total.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd0 && in_tokens != '0 && (in_data_valid || msg_count != '0))
        |-> (({1'b0, msg_count} + {1'b0, in_tokens}) <= MAXS));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_count <= MAXC);

    p_read_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_grant && !cpu_req_write) |-> (cpu_count != '0));

    p_write_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_grant && cpu_req_write) |-> (cpu_count == MAXC));

    p_excl_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd2 && msg_count != '0)
        |=> (out_valid && out_kind == 2'd0 && out_data_valid && out_tokens == $past(msg_count)));

    p_shared_give_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd1 && msg_count > ONE)
        |=> (out_valid && out_kind == 2'd0 && out_data_valid && out_tokens == ONE));

    p_req_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd0)
        |=> !(out_valid && out_kind == $past(out_kind) && out_addr == $past(out_addr)));

    p_req_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd0) |-> (out_tokens == '0 && !out_data_valid));

    p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_grant |-> cpu_req_valid);

endmodule

bind tc_coherence_ctrl tc_coherence_ctrl_chk #(
    .TOKENS (TOKENS),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_write  (cpu_req_write),
    .cpu_grant      (cpu_grant),
    .in_valid       (in_valid),
    .in_kind        (in_kind),
    .in_tokens      (in_tokens),
    .in_data_valid  (in_data_valid),
    .out_valid      (out_valid),
    .out_kind       (out_kind),
    .out_addr       (out_addr),
    .out_tokens     (out_tokens),
    .out_data_valid (out_data_valid),
    .cpu_count      (cpu_count),
    .msg_count      (msg_count)
);

// File: tb/tc_coherence_ctrl_bench.sv
`timescale 1ns/1ps
module tc_coherence_ctrl_bench;

    localparam int TOKENS = 4;
    localparam int ADDR_W = 2;
    localparam int CNT_W  = $clog2(TOKENS) + 1;
    localparam int LINES  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_grant;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [CNT_W-1:0]  in_tokens = '0;
    logic              in_data_valid = 1'b0;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [ADDR_W-1:0] out_addr;
    logic [CNT_W-1:0]  out_tokens;
    logic              out_data_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    tc_coherence_ctrl #(.TOKENS(TOKENS), .ADDR_W(ADDR_W)) u_tc_coherence_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_grant(cpu_grant),
        .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr),
        .in_tokens(in_tokens), .in_data_valid(in_data_valid),
        .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
        .out_tokens(out_tokens), .out_data_valid(out_data_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Present one incoming message for one cycle; capture the registered reply.
    task automatic send_msg(input logic [1:0] kind, input int addr, input int tok,
                            input bit dv, output bit ov, output int ok_kind,
                            output int otok, output bit odv);
        @(negedge clk);
        in_valid      = 1'b1;
        in_kind       = kind;
        in_addr       = ADDR_W'(addr);
        in_tokens     = CNT_W'(tok);
        in_data_valid = dv;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        ov      = out_valid;
        ok_kind = int'(out_kind);
        otok    = int'(out_tokens);
        odv     = out_data_valid;
    endtask

    // Drain a line with an exclusive request; returns tokens handed back.
    task automatic get_count(input int addr, output int cnt, output bit dv);
        bit ov; int k; int t;
        send_msg(2'd2, addr, 0, 1'b0, ov, k, t, dv);
        cnt = ov ? t : 0;
        if (ov && k != 0) cnt = -1;
    endtask

    task automatic set_count(input int addr, input int c);
        bit ov; int k; int t; bit d;
        int dummy; bit dd;
        get_count(addr, dummy, dd);
        if (c == TOKENS) begin
            send_msg(2'd0, addr, 2, 1'b1, ov, k, t, d);
            send_msg(2'd0, addr, c - 2, 1'b1, ov, k, t, d);
        end else if (c > 0) begin
            send_msg(2'd0, addr, c, 1'b1, ov, k, t, d);
        end
    endtask

    task automatic probe(input bit wr, input int addr, output bit g);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = ADDR_W'(addr);
        #1;
        g = cpu_grant;
        #1;
        cpu_req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        bit g; bit ov; int k; int t; bit d; int c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        for (int a = 0; a < LINES; a++) begin
            probe(1'b0, a, g);
            chk(g == 1'b0, "R1", "read grant after reset", int'(g), 0);
        end

        // Sweep every line over every count.
        for (int a = 0; a < LINES; a++) begin
            for (int cnt = 0; cnt <= TOKENS; cnt++) begin
                set_count(a, cnt);
                probe(1'b0, a, g);
                chk(g == (cnt >= 1), "R4", "read grant vs count", int'(g), int'(cnt >= 1));
                probe(1'b1, a, g);
                chk(g == (cnt == TOKENS), "R5", "write grant vs count", int'(g), int'(cnt == TOKENS));
                send_msg(2'd1, a, 0, 1'b0, ov, k, t, d);
                chk(ov == (cnt > 1), "R7", "shared reply present", int'(ov), int'(cnt > 1));
                if (cnt > 1) begin
                    chk(k == 0 && t == 1 && d, "R7", "shared reply one token", t, 1);
                end
                get_count(a, c, d);
                chk(c == ((cnt > 1) ? cnt - 1 : cnt), "R6", "drained tokens", c,
                    (cnt > 1) ? cnt - 1 : cnt);
                if (c > 0) begin
                    chk(d == 1'b1, "R6", "drain carries data", int'(d), 1);
                end
                if (cnt == TOKENS) begin
                    chk(c == TOKENS - 1, "R3", "filled to total in two transfers", c + 1, TOKENS);
                end
                get_count(a, c, d);
                chk(c == 0, "R6", "line empty after drain", c, 0);
            end
        end

        // R2 / R11: distinct counts per line stay separate.
        for (int a = 0; a < LINES; a++) set_count(a, a + 1);
        for (int a = 0; a < LINES; a++) begin
            get_count(a, c, d);
            chk(c == a + 1, "R11", "per-line count", c, a + 1);
        end
        set_count(1, 1);
        send_msg(2'd0, 1, 2, 1'b1, ov, k, t, d);
        get_count(1, c, d);
        chk(c == 3, "R2", "transfer adds to count", c, 3);

        // R10: transfer without data onto an empty line is ignored; kind 3 ignored.
        send_msg(2'd0, 0, 2, 1'b0, ov, k, t, d);
        get_count(0, c, d);
        chk(c == 0, "R10", "dataless transfer on empty line", c, 0);
        send_msg(2'd0, 0, 1, 1'b1, ov, k, t, d);
        send_msg(2'd0, 0, 2, 1'b0, ov, k, t, d);
        send_msg(2'd3, 0, 1, 1'b1, ov, k, t, d);
        chk(ov == 1'b0, "R10", "kind 3 gives no reply", int'(ov), 0);
        get_count(0, c, d);
        chk(c == 3, "R10", "dataless joins held copy, kind 3 no effect", c, 3);

        // R8: stalled read sends one shared request, then is granted.
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b0;
        cpu_req_addr  = 2'd1;
        @(posedge clk); #1;
        chk(out_valid && out_kind == 2'd1 && out_addr == 2'd1, "R8", "shared token request",
            int'(out_kind), 1);
        chk(out_tokens == '0 && !out_data_valid, "R8", "request carries nothing",
            int'(out_tokens), 0);
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R8", "request sent only once", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'd0; in_addr = 2'd1; in_tokens = 1; in_data_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(cpu_grant == 1'b1, "R4", "grant after token arrives", int'(cpu_grant), 1);
        chk(out_valid == 1'b0, "R8", "no repeat request", int'(out_valid), 0);
        @(negedge clk);
        cpu_req_valid = 1'b0;

        // R9: peer exclusive reply beats stalled write request.
        set_count(2, 2);
        set_count(3, 0);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 2'd3;
        in_valid = 1'b1; in_kind = 2'd2; in_addr = 2'd2; in_tokens = 0; in_data_valid = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid && out_kind == 2'd0 && out_addr == 2'd2 && out_tokens == 2,
            "R9", "reply first", int'(out_tokens), 2);
        @(posedge clk); #1;
        chk(out_valid && out_kind == 2'd2 && out_addr == 2'd3, "R9", "deferred exclusive request",
            int'(out_kind), 2);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        @(posedge clk); #1;

        finish_run();
    end

endmodule